// File: doc/BRIEF.md
# Interrupt Credit Coalescing Controller

This block decides when a set of descriptor rings should raise a message-signalled interrupt. Each ring keeps a count of completed descriptors that software has not yet consumed (its credits). A completion strobe from a ring adds one credit. Software hands credits back by writing a ring index together with a count, and that count is subtracted from the ring's credits. Every ring also has an auto-mask flag. The flag is set when the ring raises an interrupt, so a burst of completions produces a single request instead of one per descriptor.

When software returns every credit, the ring is unmasked and stays quiet until its next completion. When software returns only part of its credits, the ring stays masked and fires once more, which tells software that work is still waiting. A separate test-completion strobe also raises a request. The ring-to-vector mapping is fixed. Each vector has a delivery mask bit, taken from the vector table's control word, that holds that vector's request back until the bit is cleared.

Requests leave the block on a valid/ready stream that carries the vector number. Vectors that are waiting are merged, one pending flag per vector, and are sent lowest-numbered first.

Top module: `irq_credit_ctrl`

## Requirements
- R1: After reset `irq_valid` is 0, `ovf_err` is all zeros, every ring has zero credits and is unmasked, and no vector is pending.
- R2: A completion on a ring whose credit count is zero raises exactly one request and auto-masks that ring. Further completions on that ring while credits are outstanding raise no request.
- R3: Ring 0 maps to vector 0 and ring 1 maps to vector 1. A `test_done` pulse requests vector 2. Ring n (n >= 2) maps to vector n+2, so vector 3 is never requested.
- R4: A credit return that brings the count to exactly zero unmasks the ring and raises no request. The next completion on that ring raises a request again.
- R5: A credit return that leaves credits outstanding keeps the ring masked and raises one new request.
- R6: A credit return larger than the outstanding count clamps the count to zero, raises no request, unmasks the ring, and sets that ring's bit in `ovf_err`. The bit stays set until reset.
- R7: While `vec_mask[v]` is 1, a request for vector v is held pending and not presented. It is presented after the bit clears.
- R8: Once `irq_valid` is 1, it and `irq_vector` hold steady until a cycle with `irq_ready` high. A transfer happens on each clock edge where both are 1. When several vectors are pending and unmasked, the lowest-numbered one is presented first.
- R9: Repeated requests for a vector that has not yet been transferred merge into a single transfer.
- R10: A completion and a credit return for the same ring in the same cycle are treated as one return against count+1. That sum then decides between unmasking and firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| comp_strobe | input | NUM_RINGS | One bit per ring; a 1 adds one credit to that ring in this cycle |
| test_done | input | 1 | Pulse requesting the test-completion vector (2) |
| ret_valid | input | 1 | Credit return write strobe |
| ret_ring | input | RING_W | Ring index for the credit return |
| ret_count | input | CNT_W | Number of credits returned |
| vec_mask | input | NUM_VEC | Per-vector delivery mask (bit 0 of each vector's control word); 1 blocks delivery |
| irq_valid | output | 1 | Interrupt request valid |
| irq_ready | input | 1 | Consumer accepts the request |
| irq_vector | output | VEC_W | Vector number of the request |
| ovf_err | output | NUM_RINGS | Sticky per-ring flag set by an over-large credit return |

## Verification
The scoreboard first checks that a burst of completions yields one request, not one per descriptor. A design that dropped the auto-mask would send extra vectors, and the monitor reports them as unexpected. Full and partial returns are run back to back. A design that confused them would either fire after a full return or go silent after a partial one. An over-return is then followed by a completion, which catches a count that wraps instead of clamping: the wrapped ring would never fire again. Further cases run a completion and a return in the same cycle, hold back a merged request with the delivery mask, and stall the consumer. These expose a wrong vector mapping, lost or duplicated pending requests, and an output that changes while it is stalled.

// File: rtl/irq_credit_pkg.sv
package irq_credit_pkg;
  // Fixed ring-to-vector map: rings 0/1 keep their index, vector 2 is the
  // test completion, 3 is unused, data rings start at vector 4.
  function automatic int ring2vec(input int ring);
    return (ring < 2) ? ring : ring + 2;
  endfunction

  localparam int TEST_VEC = 2;
endpackage

// File: rtl/irq_ring_credit.sv
module irq_ring_credit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             comp,
  input  logic             ret_hit,
  input  logic [CNT_W-1:0] ret_count,
  output logic             fire,
  output logic             ovf
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             amask_q, amask_d;
  logic             ovf_q;
  logic             err_set;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q} + {{CNT_W{1'b0}}, comp};
    if (sum > CNT_MAX) sum = CNT_MAX;
    cnt_d   = cnt_q;
    amask_d = amask_q;
    fire    = 1'b0;
    err_set = 1'b0;
    if (ret_hit) begin
      if ({1'b0, ret_count} > sum) begin
        cnt_d   = '0;
        err_set = 1'b1;
      end else begin
        cnt_d = CNT_W'(sum - {1'b0, ret_count});
      end
      if (cnt_d == '0) begin
        amask_d = 1'b0;
      end else begin
        amask_d = 1'b1;
        fire    = 1'b1;
      end
    end else if (comp) begin
      cnt_d = CNT_W'(sum);
      if (cnt_q == '0 && !amask_q) begin
        fire    = 1'b1;
        amask_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      amask_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      amask_q <= amask_d;
      ovf_q   <= ovf_q | err_set;
    end
  end

  assign ovf = ovf_q;
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter #(
  parameter int NUM_VEC = 10,
  parameter int VEC_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_vec,
  input  logic [NUM_VEC-1:0] vec_mask,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [VEC_W-1:0]   irq_vector
);
  logic [NUM_VEC-1:0] pend_q, elig, take;
  logic [VEC_W-1:0]   pick;
  logic               load;
  logic               valid_q;
  logic [VEC_W-1:0]   vec_q;

  always_comb begin
    elig = pend_q & ~vec_mask;
    pick = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (elig[v]) pick = VEC_W'(v);
    end
    load = !valid_q && (|elig);
    take = '0;
    if (load) take[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~take) | set_vec;
      if (load) begin
        valid_q <= 1'b1;
        vec_q   <= pick;
      end else if (irq_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/irq_credit_ctrl.sv
module irq_credit_ctrl
  import irq_credit_pkg::*;
#(
  parameter int NUM_RINGS = 8,
  parameter int CNT_W     = 16,
  localparam int NUM_VEC  = NUM_RINGS + 2,
  localparam int VEC_W    = $clog2(NUM_VEC),
  localparam int RING_W   = $clog2(NUM_RINGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] comp_strobe,
  input  logic                 test_done,
  input  logic                 ret_valid,
  input  logic [RING_W-1:0]    ret_ring,
  input  logic [CNT_W-1:0]     ret_count,
  input  logic [NUM_VEC-1:0]   vec_mask,
  output logic                 irq_valid,
  input  logic                 irq_ready,
  output logic [VEC_W-1:0]     irq_vector,
  output logic [NUM_RINGS-1:0] ovf_err
);
  logic [NUM_RINGS-1:0] fire;
  logic [NUM_VEC-1:0]   set_vec;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    irq_ring_credit #(.CNT_W(CNT_W)) i_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .comp      (comp_strobe[r]),
      .ret_hit   (ret_valid && (ret_ring == RING_W'(r))),
      .ret_count (ret_count),
      .fire      (fire[r]),
      .ovf       (ovf_err[r])
    );
  end

  always_comb begin
    set_vec = '0;
    set_vec[TEST_VEC] = test_done;
    for (int r = 0; r < NUM_RINGS; r++) begin
      set_vec[ring2vec(r)] = set_vec[ring2vec(r)] | fire[r];
    end
  end

  irq_vec_arbiter #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) i_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .vec_mask   (vec_mask),
    .irq_valid  (irq_valid),
    .irq_ready  (irq_ready),
    .irq_vector (irq_vector)
  );
endmodule

// File: rtl/irq_credit_chk.sv
module irq_credit_chk #(
  parameter int NUM_RINGS = 8,
  parameter int NUM_VEC   = 10,
  parameter int VEC_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_VEC-1:0]   vec_mask,
  input logic                 irq_valid,
  input logic                 irq_ready,
  input logic [VEC_W-1:0]     irq_vector,
  input logic [NUM_RINGS-1:0] ovf_err
);
  logic [NUM_VEC-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= vec_mask;
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_vector))); // R8

  AST_NO_RSVD_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector != VEC_W'(3))); // R3

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> !mask_q[irq_vector]); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_err & $past(ovf_err)) == $past(ovf_err))); // R6

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (int'(irq_vector) < NUM_VEC)); // R3
endmodule

bind irq_credit_ctrl irq_credit_chk #(
  .NUM_RINGS(NUM_RINGS), .NUM_VEC(NUM_VEC), .VEC_W(VEC_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .vec_mask(vec_mask), .irq_valid(irq_valid),
  .irq_ready(irq_ready), .irq_vector(irq_vector), .ovf_err(ovf_err)
);

// File: tb/test_irq_credit_ctrl.sv
module test_irq_credit_ctrl;
  localparam int NR = 8;
  localparam int CW = 16;
  localparam int NV = NR + 2;
  localparam int VW = $clog2(NV);
  localparam int RW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] comp_strobe = '0;
  logic          test_done = 1'b0;
  logic          ret_valid = 1'b0;
  logic [RW-1:0] ret_ring = '0;
  logic [CW-1:0] ret_count = '0;
  logic [NV-1:0] vec_mask = '0;
  logic          irq_valid;
  logic          irq_ready = 1'b1;
  logic [VW-1:0] irq_vector;
  logic [NR-1:0] ovf_err;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int cyc = 0;

  always #10 clk = ~clk; // 50 MHz

  irq_credit_ctrl #(.NUM_RINGS(NR), .CNT_W(CW)) i_irq_credit_ctrl (
    .clk(clk), .rst_n(rst_n), .comp_strobe(comp_strobe), .test_done(test_done),
    .ret_valid(ret_valid), .ret_ring(ret_ring), .ret_count(ret_count),
    .vec_mask(vec_mask), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every transfer is compared against the scoreboard queue (R2 R3 R8 R9).
  always @(negedge clk) begin
    cyc++;
    if (rst_n && irq_valid && irq_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected request", int'(irq_vector), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(irq_vector) == e, "R3 vector order", int'(irq_vector), e);
      end
    end
  end

  initial begin
    @(negedge clk);
    wait (cyc > 20000);
    chk(1'b0, "R8 watchdog", cyc, 20000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic comp(input int ring);
    comp_strobe[ring] = 1'b1;
    @(negedge clk);
    comp_strobe = '0;
  endtask

  task automatic ret(input int ring, input int cnt);
    ret_valid = 1'b1;
    ret_ring  = RW'(ring);
    ret_count = CW'(cnt);
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic drained(input string req);
    idle(8);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    idle(3);
    // R1: reset state
    chk(irq_valid == 1'b0, "R1 valid at reset", int'(irq_valid), 0);
    chk(ovf_err == '0, "R1 ovf at reset", int'(ovf_err), 0);
    rst_n = 1'b1;
    idle(2);
    chk(irq_valid == 1'b0, "R1 valid after reset", int'(irq_valid), 0);

    // R2 R3: first completion fires once, burst coalesced
    exp_q.push_back(4);
    comp(2); comp(2); comp(2);
    drained("R2 one request per burst");

    // R5: partial return (3 -> 2) fires again, ring stays masked
    exp_q.push_back(4);
    ret(2, 1);
    drained("R5 partial return fires");
    comp(2);
    drained("R5 still masked");

    // R4: full return (3 -> 0) is quiet, then unmasked
    ret(2, 3);
    drained("R4 full return quiet");
    exp_q.push_back(4);
    comp(2);
    drained("R4 unmasked again");
    ret(2, 1);

    // R3 R8: simultaneous sources, lowest vector first
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(9);
    comp_strobe = 8'b1000_0011;
    test_done = 1'b1;
    @(negedge clk);
    comp_strobe = '0;
    test_done = 1'b0;
    drained("R3 mapping and order");
    ret(0, 1); ret(1, 1); ret(7, 1);
    drained("R4 all returned quiet");

    // R6: over-return clamps and flags
    exp_q.push_back(5);
    comp(3);
    drained("R2 ring3 fire");
    ret(3, 5);
    drained("R6 over-return quiet");
    chk(ovf_err == 8'b0000_1000, "R6 error flag", int'(ovf_err), 8);
    exp_q.push_back(5);
    comp(3);
    drained("R6 clamped to zero");
    ret(3, 1);
    idle(2);
    chk(ovf_err == 8'b0000_1000, "R6 flag sticky", int'(ovf_err), 8);

    // R7: per-vector mask holds request pending
    vec_mask[6] = 1'b1;
    comp(4);
    idle(10);
    chk(irq_valid == 1'b0, "R7 masked held", int'(irq_valid), 0);
    exp_q.push_back(6);
    vec_mask[6] = 1'b0;
    drained("R7 released after unmask");
    ret(4, 1);

    // R9: two requests for a masked vector merge
    vec_mask[6] = 1'b1;
    comp(4);
    ret(4, 0);
    idle(6);
    exp_q.push_back(6);
    vec_mask[6] = 1'b0;
    drained("R9 merged request");
    ret(4, 1);
    drained("R4 ring4 quiet");

    // R8: back-pressure holds valid and vector
    irq_ready = 1'b0;
    exp_q.push_back(7);
    comp(5);
    idle(6);
    chk(irq_valid == 1'b1, "R8 valid held", int'(irq_valid), 1);
    chk(int'(irq_vector) == 7, "R8 vector held", int'(irq_vector), 7);
    irq_ready = 1'b1;
    drained("R8 delivered after stall");
    ret(5, 1);

    // R10: same-cycle completion and full return
    exp_q.push_back(8);
    comp(6);
    drained("R2 ring6 fire");
    comp_strobe[6] = 1'b1;
    ret(6, 2);
    comp_strobe = '0;
    drained("R10 net zero quiet");
    exp_q.push_back(8);
    comp(6);
    drained("R10 unmasked after net zero");
    ret(6, 1);
    drained("R10 final quiet");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule